// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage Pipeline

This block runs a shadow pipeline next to a five-stage in-order core (fetch, decode, execute, memory, writeback). Each slot holds a valid bit, the program counter of the instruction in that slot and a vector of fault bits. The fetch, decode, execute and memory stages each raise their own fault causes. These bits are merged into the vector of the instruction that occupies the stage, and the vector then moves down the pipeline with that instruction. The vector is examined in one place only: the writeback slot, which is the commit point.

When the writeback slot holds a fault-free instruction, the block allows its state update. When the vector is non-zero, the block suppresses the update and reports an exception, giving the program counter of that instruction as the restart point and a single cause code. In that same cycle it drops every younger instruction in the upstream slots, along with any instruction being issued. Because the decision is deferred to commit, a fault raised late by an older instruction always wins over a fault raised earlier in time by a younger one.

The issue side is a plain valid/pc pair with no ready signal. This shadow pipeline never stalls, so an instruction presented with `issue_valid` is always taken on that clock edge. There is no back-pressure. The core must hold off its own issue if it needs to stall.

Top module: `prex_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `commit_valid` and `exc_valid` are 0 and `exc_cause` is 0.
- R2: An instruction issued with no fault flags appears at the commit point exactly 5 clock edges after the edge that accepted it. `commit_valid` is then 1 and `commit_pc` equals its issue pc.
- R3: Fetch faults come in on `if_fault` as bit 0 = page fault (cause 1), bit 1 = misaligned fetch (cause 2) and bit 2 = protection violation (cause 3).
- R4: The decode illegal-opcode flag `id_illegal` reports cause 4.
- R5: The execute arithmetic flag `ex_arith` reports cause 5.
- R6: Memory faults come in on `mem_fault` as bit 0 = data page fault (cause 6), bit 1 = misaligned data (cause 7) and bit 2 = protection violation (cause 8).
- R7: When one instruction has several flags set, the smallest cause code among them is reported. This is the earliest stage, and within a stage the lowest bit.
- R8: When a faulting instruction reaches the commit point, `commit_valid` is 0, `exc_valid` is 1, `exc_pc` is its pc and `exc_cause` is its code. When `exc_valid` is 0, `exc_cause` is 0.
- R9: Every instruction older than the faulting one commits. The five instructions issued after it, counting the one offered in the report cycle, never commit or report.
- R10: If two different instructions fault, the older one is reported, even if the younger one was flagged on an earlier clock edge.
- R11: Fault flags presented to a stage that holds no instruction have no effect.
- R12: An instruction issued on the edge after the report cycle runs and commits normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | An instruction enters the fetch slot on this edge |
| issue_pc | input | PC_W | Program counter of the issued instruction |
| if_fault | input | 3 | Fetch fault flags for the instruction in the fetch slot |
| id_illegal | input | 1 | Illegal opcode for the instruction in the decode slot |
| ex_arith | input | 1 | Arithmetic fault for the instruction in the execute slot |
| mem_fault | input | 3 | Memory fault flags for the instruction in the memory slot |
| commit_valid | output | 1 | Writeback instruction may update state |
| commit_pc | output | PC_W | Pc of the committing instruction |
| exc_valid | output | 1 | Exception reported; younger slots flushed |
| exc_pc | output | PC_W | Restart pc (the faulting instruction) |
| exc_cause | output | 4 | Cause code 1..8, 0 when no exception |

## Verification
The assertions assume that fault flags refer to whichever instruction currently sits in each slot. They also assume that whatever reaches commit was issued exactly five edges earlier, since the shadow pipeline never stalls. The stimulus follows this contract. It advances one instruction per cycle and computes, from the issue index alone, which slot a given instruction occupies in each cycle. Each flag is raised only in the cycle its target instance occupies the matching slot. The one deliberate exception is a pass that holds every flag high over an empty pipeline.

// File: rtl/prex_pkg.sv
package prex_pkg;
  localparam int NST    = 5;   // fetch, decode, execute, memory, writeback
  localparam int NCAUSE = 8;
  localparam int CW     = 4;

  typedef logic [NCAUSE-1:0] exc_vec_t;
  typedef logic [CW-1:0]     cause_t;

  // bit i of the vector carries cause code i+1; lower bits belong to earlier stages
  function automatic cause_t first_cause(input exc_vec_t v);
    cause_t c;
    logic   hit;
    c   = '0;
    hit = 1'b0;
    for (int i = 0; i < NCAUSE; i++) begin
      if (v[i] && !hit) begin
        c   = cause_t'(i + 1);
        hit = 1'b1;
      end
    end
    return c;
  endfunction
endpackage

// File: rtl/prex_slot.sv
module prex_slot
  import prex_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            in_vld,
  input  logic [PC_W-1:0] in_pc,
  input  exc_vec_t        in_st,
  input  exc_vec_t        raise,
  output logic            vld,
  output logic [PC_W-1:0] pc,
  output exc_vec_t        st_fwd
);
  exc_vec_t st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      pc   <= '0;
      st_q <= '0;
    end else begin
      vld  <= in_vld && !flush;
      pc   <= in_pc;
      st_q <= in_st;
    end
  end

  // merge this stage's own causes only when an instruction is present
  assign st_fwd = st_q | (vld ? raise : '0);
endmodule

// File: rtl/prex_commit.sv
module prex_commit
  import prex_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            wb_vld,
  input  logic [PC_W-1:0] wb_pc,
  input  exc_vec_t        wb_st,
  output logic            commit_valid,
  output logic [PC_W-1:0] commit_pc,
  output logic            exc_valid,
  output logic [PC_W-1:0] exc_pc,
  output cause_t          exc_cause,
  output logic            flush
);
  logic faulty;

  assign faulty       = wb_vld && (wb_st != '0);
  assign commit_valid = wb_vld && !faulty;
  assign commit_pc    = wb_pc;
  assign exc_valid    = faulty;
  assign exc_pc       = wb_pc;
  assign exc_cause    = faulty ? first_cause(wb_st) : '0;
  assign flush        = faulty;
endmodule

// File: rtl/prex_tracker.sv
module prex_tracker
  import prex_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [PC_W-1:0] issue_pc,
  input  logic [2:0]      if_fault,
  input  logic            id_illegal,
  input  logic            ex_arith,
  input  logic [2:0]      mem_fault,
  output logic            commit_valid,
  output logic [PC_W-1:0] commit_pc,
  output logic            exc_valid,
  output logic [PC_W-1:0] exc_pc,
  output logic [3:0]      exc_cause
);
  localparam int WB = NST - 1;

  exc_vec_t        raise_a [NST];
  logic            vld_a   [NST];
  logic [PC_W-1:0] pc_a    [NST];
  exc_vec_t        fwd_a   [NST];
  logic            flush;

  assign raise_a[0] = {5'b0, if_fault};
  assign raise_a[1] = {4'b0, id_illegal, 3'b0};
  assign raise_a[2] = {3'b0, ex_arith, 4'b0};
  assign raise_a[3] = {mem_fault, 5'b0};
  assign raise_a[4] = '0;

  for (genvar k = 0; k < NST; k++) begin : g_slot
    logic            src_vld;
    logic [PC_W-1:0] src_pc;
    exc_vec_t        src_st;
    if (k == 0) begin : g_head
      assign src_vld = issue_valid;
      assign src_pc  = issue_pc;
      assign src_st  = '0;
    end else begin : g_link
      assign src_vld = vld_a[k-1];
      assign src_pc  = pc_a[k-1];
      assign src_st  = fwd_a[k-1];
    end
    prex_slot #(.PC_W(PC_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .flush  (flush),
      .in_vld (src_vld),
      .in_pc  (src_pc),
      .in_st  (src_st),
      .raise  (raise_a[k]),
      .vld    (vld_a[k]),
      .pc     (pc_a[k]),
      .st_fwd (fwd_a[k])
    );
  end

  prex_commit #(.PC_W(PC_W)) u_commit (
    .wb_vld       (vld_a[WB]),
    .wb_pc        (pc_a[WB]),
    .wb_st        (fwd_a[WB]),
    .commit_valid (commit_valid),
    .commit_pc    (commit_pc),
    .exc_valid    (exc_valid),
    .exc_pc       (exc_pc),
    .exc_cause    (exc_cause),
    .flush        (flush)
  );
endmodule

// File: rtl/prex_tracker_chk.sv
module prex_tracker_chk #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_valid,
  input logic [PC_W-1:0] issue_pc,
  input logic            commit_valid,
  input logic [PC_W-1:0] commit_pc,
  input logic            exc_valid,
  input logic [PC_W-1:0] exc_pc,
  input logic [3:0]      exc_cause
);
  // R8: a faulting instruction never updates state
  a_r8_no_commit_on_exc: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_valid && exc_valid));

  // R8: cause is zero without an exception, within 1..8 with one
  a_r8_cause_range: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid ? (exc_cause >= 4'd1 && exc_cause <= 4'd8) : (exc_cause == 4'd0));

  // R9: the slot behind a reported fault was flushed
  a_r9_flush_next_empty: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (!commit_valid && !exc_valid));

  // R2: a commit is the instruction issued five edges earlier
  a_r2_commit_latency: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |-> ($past(issue_valid, 5) && $past(issue_pc, 5) == commit_pc));

  // R11: an exception always belongs to an issued instruction
  a_r11_exc_from_issue: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> ($past(issue_valid, 5) && $past(issue_pc, 5) == exc_pc));
endmodule

bind prex_tracker prex_tracker_chk #(.PC_W(PC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .issue_valid  (issue_valid),
  .issue_pc     (issue_pc),
  .commit_valid (commit_valid),
  .commit_pc    (commit_pc),
  .exc_valid    (exc_valid),
  .exc_pc       (exc_pc),
  .exc_cause    (exc_cause)
);

// File: tb/prex_tracker_test.sv
module prex_tracker_test;
  localparam int PERIOD = 10;
  localparam int PC_W   = 32;
  localparam int N      = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            issue_valid = 1'b0;
  logic [PC_W-1:0] issue_pc = '0;
  logic [2:0]      if_fault = '0;
  logic            id_illegal = 1'b0;
  logic            ex_arith = 1'b0;
  logic [2:0]      mem_fault = '0;
  logic            commit_valid, exc_valid;
  logic [PC_W-1:0] commit_pc, exc_pc;
  logic [3:0]      exc_cause;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  prex_tracker #(.PC_W(PC_W)) uut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_pc(issue_pc),
    .if_fault(if_fault), .id_illegal(id_illegal), .ex_arith(ex_arith),
    .mem_fault(mem_fault), .commit_valid(commit_valid), .commit_pc(commit_pc),
    .exc_valid(exc_valid), .exc_pc(exc_pc), .exc_cause(exc_cause)
  );

  function automatic int stage_of(input int c);
    if (c < 3) return 0;
    if (c == 3) return 1;
    if (c == 4) return 2;
    return 3;
  endfunction

  function automatic logic [PC_W-1:0] pc_of(input int run, input int n);
    return PC_W'(32'h1000_0000 + run * 32'h100 + n * 4);
  endfunction

  task automatic check(input string tag, input logic [PC_W+5:0] act, input logic [PC_W+5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle_expect(input string tag);
    check(tag, {commit_valid, exc_valid, exc_cause, exc_pc}, {1'b0, 1'b0, 4'd0, exc_pc});
  endtask

  // cause index c in 0..7 maps to code c+1 and to a slot by stage_of
  task automatic run(input int rn, input int na, input int ca, input int nb, input int cb);
    int w, wc;
    string ctag;
    if (na < nb) begin w = na; wc = ca + 1; end
    else if (nb < na) begin w = nb; wc = cb + 1; end
    else begin w = na; wc = (ca < cb ? ca : cb) + 1; end
    if (na != nb) ctag = "R10";
    else if (ca != cb) ctag = "R7";
    else begin
      case (stage_of(ca))
        0: ctag = "R3";
        1: ctag = "R4";
        2: ctag = "R5";
        default: ctag = "R6";
      endcase
    end
    for (int k = 0; k < N + 6; k++) begin
      int n;
      logic [2:0] f_if, f_mem;
      logic f_id, f_ex;
      @(negedge clk);
      n = k - 5;
      if (n < 0 || n >= N) idle_expect("R9");
      else if (n < w) check("R2", {commit_valid, exc_valid, commit_pc},
                              {1'b1, 1'b0, pc_of(rn, n)});
      else if (n == w) begin
        check("R8", {commit_valid, exc_valid, exc_pc}, {1'b0, 1'b1, pc_of(rn, n)});
        check(ctag, {PC_W'(0), 2'b0, exc_cause}, {PC_W'(0), 2'b0, 4'(wc)});
      end else if (n <= w + 5) idle_expect("R9");
      else check("R12", {commit_valid, exc_valid, commit_pc},
                 {1'b1, 1'b0, pc_of(rn, n)});
      issue_valid = (k < N);
      issue_pc    = pc_of(rn, k);
      f_if = '0; f_id = 1'b0; f_ex = 1'b0; f_mem = '0;
      for (int j = 0; j < 2; j++) begin
        int ni, ci, s;
        ni = (j == 0) ? na : nb;
        ci = (j == 0) ? ca : cb;
        s  = stage_of(ci);
        if (k - 1 - s == ni) begin
          case (s)
            0: f_if[ci] = 1'b1;
            1: f_id = 1'b1;
            2: f_ex = 1'b1;
            default: f_mem[ci-5] = 1'b1;
          endcase
        end
      end
      if_fault = f_if; id_illegal = f_id; ex_arith = f_ex; mem_fault = f_mem;
    end
  endtask

  initial begin
    int rn;
    // R1: in reset and just after
    repeat (3) @(negedge clk);
    idle_expect("R1");
    rst_n = 1'b1;
    @(negedge clk);
    idle_expect("R1");
    // R11: flags on an empty pipeline
    if_fault = 3'b111; id_illegal = 1'b1; ex_arith = 1'b1; mem_fault = 3'b111;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      idle_expect("R11");
    end
    if_fault = '0; id_illegal = 1'b0; ex_arith = 1'b0; mem_fault = '0;
    repeat (6) begin
      @(negedge clk);
      idle_expect("R11");
    end
    // sweep: both cause indices, second instruction position
    rn = 0;
    for (int ca = 0; ca < 8; ca++)
      for (int cb = 0; cb < 8; cb++)
        for (int nb = 0; nb < 5; nb++) begin
          run(rn, 2, ca, nb, cb);
          rn++;
        end
    issue_valid = 1'b0;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule